// File: doc/BRIEF.md
# PCI Memory Target with Fast Device Select

This block is a target on a 32-bit PCI bus that answers memory reads and memory writes falling inside one address window. The window is set by a base address and a power-of-two size taken from configuration inputs. When an address phase hits the window, the block claims the cycle with the fast device-select timing. It then runs any number of data phases against a simple synchronous single-port memory, and it returns the bus to idle when the master ends the burst.

The block has no tri-state pads. Every signal it may drive comes with a drive-enable output: one for AD, one for PAR, and one shared by TRDY and DEVSEL. The memory side uses a word address, a read strobe whose data arrives one clock later, and one write strobe per byte lane. Read data is fetched one word ahead, so a burst can move one word on every clock.

Top module: `pcit_target`

## Requirements
- R1: When an address phase is sampled with command 4'b0110 (memory read) or 4'b0111 (memory write) on `cbe_n`, and with an address inside the window, `devsel_n` is driven low with `ctl_oe` high in the clock right after that sampling edge. `devsel_speed` always reads 2'b00. An address is inside the window when bits [31:`cfg_size_log2`] of the address equal the same bits of `cfg_base`.
- R2: An address outside the window, or any other command, leaves `devsel_n` high, `ctl_oe` and `ad_oe` low, and all `mem_we` bits zero.
- R3: On a write, each clock edge where `irdy_n` and `trdy_n` are both low stores the lanes whose `cbe_n` bit is 0 into memory word `addr[MEM_AW+1:2] + n`, where n is the index of the data phase. The word index wraps modulo the memory depth.
- R4: A data phase with `cbe_n` = 4'hF still completes and still moves the burst address on. A write phase like this stores nothing, and a read phase leaves the memory unchanged.
- R5: On a read, `ad_oe` stays low for the clock where DEVSEL is first asserted, which is the turnaround clock. In the next clock `ad_oe` and `trdy_n` become active and the first word is on `ad_out`. Each later word follows with address + 4 bytes, and `ad_out` holds steady while the master inserts waits.
- R6: During the address clock the block drives none of TRDY, DEVSEL or AD: `ctl_oe` and `ad_oe` are low.
- R7: `par_out` is the XOR of the 32 `ad_out` bits and the 4 `cbe_n` bits of the previous clock. This holds whatever the byte enables are. `par_oe` equals `ad_oe` delayed by one clock.
- R8: After the transfer taken with `frame_n` high, the block drives `devsel_n` and `trdy_n` high with `ctl_oe` high for exactly one clock, then drops `ctl_oe`. `ad_oe` drops right after that final transfer.
- R9: Byte enables are taken afresh in every data phase, so one write burst may store a different set of lanes in each word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cfg_base | input | 32 | Window base address |
| cfg_size_log2 | input | 5 | Window size as log2 of bytes |
| frame_n | input | 1 | FRAME from the master, active low |
| irdy_n | input | 1 | IRDY from the master, active low |
| ad_in | input | 32 | Address/data lines as seen on the bus |
| cbe_n | input | 4 | Command / byte-enable lines |
| ad_out | output | 32 | Read data driven on AD |
| ad_oe | output | 1 | Drive enable for AD |
| par_out | output | 1 | Even parity over AD and C/BE |
| par_oe | output | 1 | Drive enable for PAR |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| ctl_oe | output | 1 | Drive enable for DEVSEL and TRDY |
| devsel_speed | output | 2 | Device-select timing code, fixed fast |
| mem_addr | output | MEM_AW | Memory word address |
| mem_re | output | 1 | Memory read strobe; data is due one clock later |
| mem_rdata | input | 32 | Memory read data |
| mem_we | output | 4 | Per-lane memory write strobes |
| mem_wdata | output | 32 | Memory write data |

## Verification
DEVSEL is due one edge after the address is sampled. On a write, TRDY is asserted in that same clock, so the first transfer can happen at the next edge. On a read, AD and TRDY come one clock later still. PAR and its enable lag AD by one clock, and memory write strobes appear combinationally in the clock that ends in a transfer. The bench drives at the falling edge and reads the outputs there. It decides whether a transfer happens from the `trdy_n` it sees at that falling edge, which is the value the next rising edge will sample. A separate process checks PAR 2 ns after each falling edge against the AD and C/BE values it saved one clock before.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

    localparam logic [3:0] CMD_MEM_READ  = 4'b0110;
    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_TURN,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_TAIL
    } pcit_state_e;

    function automatic logic even_parity(input logic [31:0] d, input logic [3:0] c);
        return ^{d, c};
    endfunction

endpackage

// File: rtl/pcit_decode.sv
module pcit_decode
    import pcit_pkg::*;
(
    input  logic [31:0] ad,
    input  logic [3:0]  cbe_n,
    input  logic [31:0] base,
    input  logic [4:0]  size_log2,
    output logic        hit_rd,
    output logic        hit_wr
);

    logic [31:0] low_mask;
    logic        in_window;

    always_comb begin
        low_mask  = (32'd1 << size_log2) - 32'd1;
        in_window = ((ad ^ base) & ~low_mask) == 32'd0;
        hit_rd    = in_window && (cbe_n == CMD_MEM_READ);
        hit_wr    = in_window && (cbe_n == CMD_MEM_WRITE);
    end

endmodule

// File: rtl/pcit_parity.sv
module pcit_parity
    import pcit_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ad_oe,
    input  logic [31:0] ad,
    input  logic [3:0]  cbe_n,
    output logic        par,
    output logic        par_oe
);

    typedef struct packed {
        logic par;
        logic oe;
    } par_regs_t;

    par_regs_t p_d, p_q;

    always_comb begin
        p_d.par = even_parity(ad, cbe_n);
        p_d.oe  = ad_oe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign par    = p_q.par;
    assign par_oe = p_q.oe;

endmodule

// File: rtl/pcit_target.sv
module pcit_target
    import pcit_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_base,
    input  logic [4:0]        cfg_size_log2,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [31:0]       ad_in,
    input  logic [3:0]        cbe_n,
    output logic [31:0]       ad_out,
    output logic              ad_oe,
    output logic              par_out,
    output logic              par_oe,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              ctl_oe,
    output logic [1:0]        devsel_speed,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_re,
    input  logic [31:0]       mem_rdata,
    output logic [3:0]        mem_we,
    output logic [31:0]       mem_wdata
);

    localparam int WORD_LSB = 2;
    localparam int LANES    = 4;
    localparam logic [MEM_AW-1:0] STEP1 = MEM_AW'(1);
    localparam logic [MEM_AW-1:0] STEP2 = MEM_AW'(2);

    typedef struct packed {
        pcit_state_e       st;
        logic [MEM_AW-1:0] cur;
        logic [31:0]       ad;
        logic              ad_oe;
        logic              devsel_n;
        logic              trdy_n;
        logic              ctl_oe;
        logic              bus_idle;
    } tgt_regs_t;

    tgt_regs_t r_d, r_q;

    logic              hit_rd, hit_wr;
    logic              addr_phase, xfer, last_xfer;
    logic [MEM_AW-1:0] start_word;

    pcit_decode u_decode (
        .ad        (ad_in),
        .cbe_n     (cbe_n),
        .base      (cfg_base),
        .size_log2 (cfg_size_log2),
        .hit_rd    (hit_rd),
        .hit_wr    (hit_wr)
    );

    assign start_word = ad_in[MEM_AW+WORD_LSB-1:WORD_LSB];
    assign addr_phase = (r_q.st == ST_IDLE) && r_q.bus_idle && !frame_n;
    assign xfer       = !irdy_n && !r_q.trdy_n;
    assign last_xfer  = xfer && frame_n;

    always_comb begin
        r_d          = r_q;
        r_d.bus_idle = frame_n && irdy_n;
        mem_addr     = r_q.cur;
        mem_re       = 1'b0;
        mem_we       = '0;
        mem_wdata    = ad_in;

        case (r_q.st)
            ST_IDLE: begin
                if (addr_phase && (hit_rd || hit_wr)) begin
                    r_d.devsel_n = 1'b0;
                    r_d.ctl_oe   = 1'b1;
                    r_d.cur      = start_word;
                    if (hit_rd) begin
                        r_d.st   = ST_RD_TURN;
                        mem_addr = start_word;
                        mem_re   = 1'b1;
                    end else begin
                        r_d.st     = ST_WR_DATA;
                        r_d.trdy_n = 1'b0;
                    end
                end
            end
            ST_RD_TURN: begin
                r_d.ad     = mem_rdata;
                r_d.ad_oe  = 1'b1;
                r_d.trdy_n = 1'b0;
                r_d.st     = ST_RD_DATA;
                mem_addr   = r_q.cur + STEP1;
                mem_re     = 1'b1;
            end
            ST_RD_DATA: begin
                mem_re   = 1'b1;
                mem_addr = r_q.cur + STEP1;
                if (xfer) begin
                    r_d.cur  = r_q.cur + STEP1;
                    r_d.ad   = mem_rdata;
                    mem_addr = r_q.cur + STEP2;
                    if (last_xfer) begin
                        r_d.st       = ST_TAIL;
                        r_d.ad_oe    = 1'b0;
                        r_d.trdy_n   = 1'b1;
                        r_d.devsel_n = 1'b1;
                        mem_re       = 1'b0;
                    end
                end
            end
            ST_WR_DATA: begin
                if (xfer) begin
                    for (int k = 0; k < LANES; k++) begin
                        mem_we[k] = !cbe_n[k];
                    end
                    r_d.cur = r_q.cur + STEP1;
                    if (last_xfer) begin
                        r_d.st       = ST_TAIL;
                        r_d.trdy_n   = 1'b1;
                        r_d.devsel_n = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                r_d.ctl_oe = 1'b0;
                r_d.st     = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.devsel_n <= 1'b1;
            r_q.trdy_n   <= 1'b1;
            r_q.bus_idle <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    pcit_parity u_parity (
        .clk    (clk),
        .rst_n  (rst_n),
        .ad_oe  (r_q.ad_oe),
        .ad     (r_q.ad),
        .cbe_n  (cbe_n),
        .par    (par_out),
        .par_oe (par_oe)
    );

    assign ad_out       = r_q.ad;
    assign ad_oe        = r_q.ad_oe;
    assign devsel_n     = r_q.devsel_n;
    assign trdy_n       = r_q.trdy_n;
    assign ctl_oe       = r_q.ctl_oe;
    assign devsel_speed = 2'b00;

    AST_DEVSEL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && (hit_rd || hit_wr)) |=> (!devsel_n && ctl_oe)); // R1
    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && !hit_rd && !hit_wr) |=> (devsel_n && !ctl_oe)); // R2
    AST_WE_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we) |-> (!irdy_n && !trdy_n && !devsel_n)); // R3
    AST_EMPTY_BE: assert property (@(posedge clk) disable iff (!rst_n)
        (cbe_n == 4'hF) |-> (mem_we == 4'h0)); // R4
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && !trdy_n && irdy_n) |=> $stable(ad_out)); // R5
    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.bus_idle && !frame_n) |-> (!ctl_oe && !ad_oe)); // R6
    AST_PAR_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ad_oe) |-> par_oe); // R7
    AST_TAIL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_n) |-> (ctl_oe && trdy_n)); // R8
    AST_TAIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_n) |=> !ctl_oe); // R8

endmodule

// File: tb/sim_pcit_target.sv
module sim_pcit_target;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   cfg_base = BASE;
    logic [4:0]    cfg_size_log2 = 5'd8;
    logic          frame_n = 1'b1;
    logic          irdy_n = 1'b1;
    logic [31:0]   ad_in = '0;
    logic [3:0]    cbe_n = '0;
    logic [31:0]   ad_out;
    logic          ad_oe, par_out, par_oe, devsel_n, trdy_n, ctl_oe;
    logic [1:0]    devsel_speed;
    logic [AW-1:0] mem_addr;
    logic          mem_re;
    logic [31:0]   mem_rdata;
    logic [3:0]    mem_we;
    logic [31:0]   mem_wdata;

    logic [31:0] mem_model [DEPTH];
    logic [31:0] ref_mem   [DEPTH];

    int n_tests = 0;
    int n_fail  = 0;

    logic prev_oe  = 1'b0;
    logic prev_par = 1'b0;

    always #10 clk = ~clk;

    pcit_target #(.MEM_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size_log2(cfg_size_log2),
        .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in), .cbe_n(cbe_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .ctl_oe(ctl_oe), .devsel_speed(devsel_speed),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    function automatic logic [31:0] init_word(input int j);
        return (32'(j) * 32'h0101_0101) ^ 32'hA5A5_0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) mem_model[j] <= init_word(j);
            mem_rdata <= '0;
        end else begin
            if (mem_re) mem_rdata <= mem_model[mem_addr];
            for (int k = 0; k < 4; k++)
                if (mem_we[k]) mem_model[mem_addr][8*k +: 8] <= mem_wdata[8*k +: 8];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // R7: parity and its enable lag AD by one clock
    always @(negedge clk) begin
        if (rst_n) begin
            #2;
            check(par_oe == prev_oe, "R7", "par_oe lag", 32'(par_oe), 32'(prev_oe));
            if (prev_oe)
                check(par_out == prev_par, "R7", "par value", 32'(par_out), 32'(prev_par));
            prev_oe  = ad_oe;
            prev_par = ^{ad_out, cbe_n};
        end
    end

    task automatic compare_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int j = 0; j < DEPTH; j++)
            if (mem_model[j] !== ref_mem[j]) begin
                bad++;
                if (first < 0) first = j;
            end
        if (first < 0) first = 0;
        check(bad == 0, req, "memory image", mem_model[first], ref_mem[first]);
    endtask

    task automatic addr_phase(input logic [31:0] addr, input logic [3:0] cmd);
        @(negedge clk);
        check(!ctl_oe && !ad_oe && devsel_n, "R6", "quiet before address", 32'({ctl_oe, ad_oe}), 32'd0);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    endtask

    task automatic finish_tail(input string kind);
        frame_n = 1'b1; irdy_n = 1'b1; ad_in = $urandom; cbe_n = 4'h0;
        check(devsel_n && trdy_n && ctl_oe && !ad_oe, "R8", {kind, " tail drive"},
              32'({devsel_n, trdy_n, ctl_oe, ad_oe}), 32'b1110);
        @(negedge clk);
        check(!ctl_oe && devsel_n, "R8", {kind, " release"}, 32'({ctl_oe, devsel_n}), 32'b01);
    endtask

    task automatic wr_burst(input logic [5:0] word, input int n, input int empty_at);
        int i = 0;
        int wt = int'($urandom % 3);
        logic [31:0] d = $urandom;
        logic [3:0]  be = (empty_at == 0) ? 4'hF : 4'($urandom);
        addr_phase(BASE | (32'(word) << 2), 4'b0111);
        @(negedge clk);
        check(!devsel_n && ctl_oe, "R1", "write devsel fast", 32'({devsel_n, ctl_oe}), 32'b01);
        while (i < n) begin
            if (wt > 0) begin
                irdy_n = 1'b1; frame_n = 1'b0; ad_in = $urandom; cbe_n = 4'($urandom); wt--;
            end else begin
                irdy_n = 1'b0; frame_n = (i == n - 1); ad_in = d; cbe_n = be;
            end
            if (!irdy_n && !trdy_n) begin
                logic [5:0] w = word + 6'(i);
                for (int k = 0; k < 4; k++)
                    if (!be[k]) ref_mem[w][8*k +: 8] = d[8*k +: 8];
                i++;
                d  = $urandom;
                be = (i == empty_at) ? 4'hF : 4'($urandom);
                wt = int'($urandom % 3);
            end
            @(negedge clk);
        end
        finish_tail("write");
        compare_mem("R3 R4 R9");
    endtask

    task automatic rd_burst(input logic [5:0] word, input int n);
        int i = 0;
        int wt = int'($urandom % 3);
        bit held = 1'b0;
        logic [31:0] held_val = '0;
        addr_phase(BASE | (32'(word) << 2), 4'b0110);
        @(negedge clk);
        check(!devsel_n && ctl_oe && !ad_oe && trdy_n, "R5", "read turnaround",
              32'({devsel_n, ctl_oe, ad_oe, trdy_n}), 32'b0101);
        while (i < n) begin
            if (held)
                check(ad_out == held_val, "R5", "hold during wait", ad_out, held_val);
            if (wt > 0) begin
                irdy_n = 1'b1; frame_n = 1'b0; wt--;
            end else begin
                irdy_n = 1'b0; frame_n = (i == n - 1);
            end
            ad_in = $urandom;
            cbe_n = ($urandom % 4 == 0) ? 4'hF : 4'($urandom);
            held = irdy_n && !trdy_n;
            held_val = ad_out;
            if (!irdy_n && !trdy_n) begin
                logic [5:0] w = word + 6'(i);
                check(ad_oe && ad_out == ref_mem[w], "R5", "read data", ad_out, ref_mem[w]);
                i++;
                wt = int'($urandom % 3);
            end
            @(negedge clk);
        end
        finish_tail("read");
        compare_mem("R4");
    endtask

    task automatic miss_txn(input logic [31:0] addr, input logic [3:0] cmd);
        addr_phase(addr, cmd);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            irdy_n = 1'b0; frame_n = 1'b1; ad_in = $urandom;
            check(devsel_n && !ctl_oe && !ad_oe && mem_we == 4'h0, "R2", "no claim",
                  32'({devsel_n, ctl_oe, ad_oe, mem_we}), 32'b1000000);
        end
        @(negedge clk);
        irdy_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd4242);
        for (int j = 0; j < DEPTH; j++) ref_mem[j] = init_word(j);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(devsel_n && trdy_n && !ctl_oe && !ad_oe && !par_oe, "R8", "reset state",
              32'({devsel_n, trdy_n, ctl_oe, ad_oe, par_oe}), 32'b11000);
        check(devsel_speed == 2'b00, "R1", "fast timing code", 32'(devsel_speed), 32'd0);

        wr_burst(6'd3, 1, -1);
        rd_burst(6'd3, 1);
        wr_burst(6'd8, 4, 2);
        wr_burst(6'd20, 3, 0);
        rd_burst(6'd7, 6);
        wr_burst(6'd62, 4, -1);
        rd_burst(6'd61, 5);
        miss_txn(BASE + 32'h100, 4'b0111);
        miss_txn(BASE + 32'h10, 4'b0010);
        miss_txn(32'h8000_0000, 4'b0110);

        for (int t = 0; t < 60; t++) begin
            int kind = int'($urandom % 5);
            logic [5:0] w = 6'($urandom);
            int len = 1 + int'($urandom % 6);
            if (kind < 2)       wr_burst(w, len, int'($urandom % 8));
            else if (kind < 4)  rd_burst(w, len);
            else                miss_txn(BASE + 32'h100 + (32'(w) << 2), 4'b0110);
        end

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R1..R9 run hung: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule